// File: doc/BRIEF.md
# Status-Mapping Receive Channel Packer

This block is one receive channel of a gateway that bridges serial avionics links onto a switched Ethernet backbone. A protocol receiver hands it one parallel word at a time. The block checks that the word is well formed and reduces the word's status to an 8-bit functional-status (FS) code. That code decides the word's fate: the word is discarded, or it is kept with its data set (DS) forced to zero, or it is kept unchanged. A kept word is stored as an `{FS, DS}` entry in a 64-deep first-in first-out buffer.

One parameter selects the input kind. The choices are a 32-bit ARINC 429 word, a CAN-style frame (a 5-bit status/length field above 64 data bits), or a UART packet made of a status byte and 32 or 64 data bits. A small trigger state machine watches the buffer and pulses `frame_start` for one cycle to release the stored batch to a downstream framer. In event mode it fires when the entry count reaches a threshold. In periodic mode it fires when a millisecond-based period expires and the buffer is not empty. The framer drains the buffer through `rd_en` and `rd_entry`, then reports completion on `drain_done`.

The trigger machine has three states:
- `TS_COLLECT`: waiting for a trigger condition.
- `TS_FIRE`: the single cycle in which `frame_start` is high.
- `TS_DRAIN`: waiting for the framer.

It has three transitions:
- `TS_COLLECT` to `TS_FIRE` when the trigger condition holds.
- `TS_FIRE` to `TS_DRAIN`, unconditionally.
- `TS_DRAIN` to `TS_COLLECT` on `drain_done`.

Top module: `stat_pack_chan`

## Requirements
- R1: FS codes are 0x00 (no data), 0x03 (normal), 0x0C (functional test) and 0x30 (no computed data). A word whose FS is 0x00 is not stored. A word whose FS is 0x30 is stored with its DS set to all zeros. A word whose FS is 0x03 or 0x0C is stored with its DS unchanged. A stored entry holds FS in its top 8 bits and DS below it.
- R2: ARINC 429 kind: parity is odd over all 32 bits, and a word with even parity is not stored. Bits 30:29 map as follows: 11 to 0x03, 10 to 0x0C, 01 to 0x30, and 00 to 0x00. The DS is the whole 32-bit word, so the entry is 40 bits.
- R3: UART kind: the status byte occupies the top 8 bits of the word and the data occupies the low `UART_DS_W` bits. Status bytes 0x03, 0x0C and 0x30 become the FS unchanged. Status 0x00 and every value outside the four codes are not stored.
- R4: CAN-style kind: the word is 69 bits, with bit 68 a flag and bits 67:64 a length code. With length 8, flag 0 maps to 0x03 and flag 1 maps to 0x0C. With length 0, flag 0 maps to 0x30 and flag 1 maps to 0x00. Any other length is not stored. The DS is bits 63:0.
- R5: The buffer holds 64 entries, is read in write order, and shows the oldest entry on `rd_entry`. `fifo_count` reports the number of entries it holds. A kept word that arrives while the buffer is full is dropped, and the count stays at 64. A read while the buffer is empty changes nothing.
- R6: Event mode (`cfg_periodic`=0): when a write makes `fifo_count` reach `cfg_threshold`, `frame_start` goes high for exactly one cycle. It goes high in the second cycle after that write's clock edge.
- R7: Periodic mode (`cfg_periodic`=1): the period lasts `cfg_period_ms` ticks of `TICK_CYCLES` clocks each. When a period expires and the buffer holds entries, `frame_start` pulses. When a period expires and the buffer is empty, there is no pulse.
- R8: After a pulse, no further pulse is issued until `drain_done` is seen. If the trigger condition still holds after `drain_done`, the block fires again.
- R9: After reset, `fifo_count` is 0, `fifo_empty` is 1 and `frame_start` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A word is present on in_word |
| in_word | input | IN_W | Received word; layout set by KIND |
| cfg_periodic | input | 1 | 1 selects periodic trigger, 0 selects event trigger |
| cfg_threshold | input | CW | Event threshold, 1 to 64 entries |
| cfg_period_ms | input | PER_W | Period in ticks, 5 to 320 |
| rd_en | input | 1 | Framer pops the oldest entry |
| drain_done | input | 1 | Framer has finished draining |
| rd_entry | output | ENTRY_W | Oldest stored {FS, DS} entry |
| fifo_count | output | CW | Number of stored entries |
| fifo_empty | output | 1 | Buffer holds nothing |
| frame_start | output | 1 | One-cycle framing-start pulse |

## Verification
The assertions check on every cycle that:
- the count never passes 64;
- a full buffer with no read stays full, and an empty buffer with no write stays empty;
- `frame_start` is never wider than one cycle and never repeats before `drain_done`;
- every visible entry carries a legal FS code, and an entry with FS 0x30 carries a zero DS.

Only the bench scenarios can show the rest:
- that each input kind's status field picks the right code;
- that bad parity and bad length or status values are dropped;
- the exact cycle of the event pulse;
- the refiring after `drain_done`;
- that an expired period with an empty buffer stays silent.

// File: rtl/stat_pack_pkg.sv
package stat_pack_pkg;

    localparam int KIND_A429 = 0;
    localparam int KIND_CAN  = 1;
    localparam int KIND_UART = 2;

    localparam logic [7:0] FS_ND  = 8'h00;
    localparam logic [7:0] FS_NO  = 8'h03;
    localparam logic [7:0] FS_FT  = 8'h0C;
    localparam logic [7:0] FS_NCD = 8'h30;

    typedef enum logic [1:0] {
        TS_COLLECT,
        TS_FIRE,
        TS_DRAIN
    } trig_state_e;

    function automatic int in_width(input int kind, input int uart_ds);
        case (kind)
            KIND_A429: return 32;
            KIND_CAN:  return 69;
            default:   return 8 + uart_ds;
        endcase
    endfunction

    function automatic int ds_width(input int kind, input int uart_ds);
        case (kind)
            KIND_A429: return 32;
            KIND_CAN:  return 64;
            default:   return uart_ds;
        endcase
    endfunction

endpackage

// File: rtl/stat_pack_map.sv
module stat_pack_map
    import stat_pack_pkg::*;
#(
    parameter  int KIND      = KIND_UART,
    parameter  int UART_DS_W = 64,
    localparam int IN_W      = in_width(KIND, UART_DS_W),
    localparam int DS_W      = ds_width(KIND, UART_DS_W),
    localparam int ENTRY_W   = 8 + DS_W
) (
    input  logic [IN_W-1:0]    word,
    output logic               keep,
    output logic [ENTRY_W-1:0] entry
);

    logic [7:0]      fs;
    logic [DS_W-1:0] ds_raw;
    logic            form_ok;

    generate
        if (KIND == KIND_A429) begin : g_a429
            always_comb begin
                form_ok = ^word;
                ds_raw  = word;
                unique case (word[30:29])
                    2'b11:   fs = FS_NO;
                    2'b10:   fs = FS_FT;
                    2'b01:   fs = FS_NCD;
                    default: fs = FS_ND;
                endcase
            end
        end else if (KIND == KIND_CAN) begin : g_can
            logic       flag;
            logic [3:0] len;
            assign flag = word[68];
            assign len  = word[67:64];
            always_comb begin
                ds_raw  = word[63:0];
                form_ok = (len == 4'd8) || (len == 4'd0);
                if (len == 4'd8) begin
                    fs = flag ? FS_FT : FS_NO;
                end else begin
                    fs = flag ? FS_ND : FS_NCD;
                end
            end
        end else begin : g_uart
            logic [7:0] status;
            assign status = word[IN_W-1 -: 8];
            always_comb begin
                ds_raw = word[DS_W-1:0];
                fs     = status;
                unique case (status)
                    FS_NO, FS_FT, FS_NCD, FS_ND: form_ok = 1'b1;
                    default:                     form_ok = 1'b0;
                endcase
            end
        end
    endgenerate

    always_comb begin
        keep  = form_ok && (fs != FS_ND);
        entry = {fs, (fs == FS_NCD) ? {DS_W{1'b0}} : ds_raw};
    end

endmodule

// File: rtl/stat_pack_fifo.sv
module stat_pack_fifo #(
    parameter  int W     = 72,
    parameter  int DEPTH = 64,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    input  logic          rd_en,
    output logic [W-1:0]  rd_data,
    output logic [CW-1:0] count,
    output logic          empty
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr;
    logic [AW-1:0] rptr;
    logic [CW-1:0] cnt;
    logic          wr_ok;
    logic          rd_ok;

    assign wr_ok   = wr_en && (cnt != CW'(DEPTH));
    assign rd_ok   = rd_en && (cnt != '0);
    assign rd_data = mem[rptr];
    assign count   = cnt;
    assign empty   = (cnt == '0);

    always_ff @(posedge clk) begin
        if (wr_ok) begin
            mem[wptr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (wr_ok) begin
                wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
            end
            if (rd_ok) begin
                rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
            end
            unique case ({wr_ok, rd_ok})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

endmodule

// File: rtl/stat_pack_trig.sv
module stat_pack_trig
    import stat_pack_pkg::*;
#(
    parameter  int CW          = 7,
    parameter  int PER_W       = 9,
    parameter  int TICK_CYCLES = 50000,
    localparam int TW          = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CW-1:0]    count,
    input  logic             periodic,
    input  logic [CW-1:0]    threshold,
    input  logic [PER_W-1:0] period,
    input  logic             drain_done,
    output logic             frame_start
);

    trig_state_e      state;
    trig_state_e      state_nx;
    logic [TW-1:0]    tick_cnt;
    logic [PER_W-1:0] ms_cnt;
    logic [PER_W:0]   ms_plus;
    logic             tick;
    logic             expire;
    logic             fire_cond;

    assign tick    = (tick_cnt == TW'(TICK_CYCLES - 1));
    assign ms_plus = {1'b0, ms_cnt} + {{PER_W{1'b0}}, 1'b1};
    assign expire  = tick && (ms_plus >= {1'b0, period});

    always_ff @(posedge clk) begin
        if (!rst_n || !periodic) begin
            tick_cnt <= '0;
            ms_cnt   <= '0;
        end else begin
            tick_cnt <= tick ? '0 : tick_cnt + 1'b1;
            if (expire) begin
                ms_cnt <= '0;
            end else if (tick) begin
                ms_cnt <= ms_cnt + 1'b1;
            end
        end
    end

    always_comb begin
        if (count == '0) begin
            fire_cond = 1'b0;
        end else if (periodic) begin
            fire_cond = expire;
        end else begin
            fire_cond = (count >= threshold);
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            TS_COLLECT: if (fire_cond)  state_nx = TS_FIRE;
            TS_FIRE:                    state_nx = TS_DRAIN;
            TS_DRAIN:   if (drain_done) state_nx = TS_COLLECT;
            default:                    state_nx = TS_COLLECT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= TS_COLLECT;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        frame_start = (state == TS_FIRE);
    end

endmodule

// File: rtl/stat_pack_chan.sv
module stat_pack_chan
    import stat_pack_pkg::*;
#(
    parameter  int KIND        = KIND_UART,
    parameter  int UART_DS_W   = 64,
    parameter  int DEPTH       = 64,
    parameter  int PER_W       = 9,
    parameter  int TICK_CYCLES = 50000,
    localparam int IN_W        = in_width(KIND, UART_DS_W),
    localparam int DS_W        = ds_width(KIND, UART_DS_W),
    localparam int ENTRY_W     = 8 + DS_W,
    localparam int CW          = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [IN_W-1:0]    in_word,
    input  logic               cfg_periodic,
    input  logic [CW-1:0]      cfg_threshold,
    input  logic [PER_W-1:0]   cfg_period_ms,
    input  logic               rd_en,
    input  logic               drain_done,
    output logic [ENTRY_W-1:0] rd_entry,
    output logic [CW-1:0]      fifo_count,
    output logic               fifo_empty,
    output logic               frame_start
);

    logic               map_keep;
    logic [ENTRY_W-1:0] map_entry;

    stat_pack_map #(
        .KIND      (KIND),
        .UART_DS_W (UART_DS_W)
    ) u_map (
        .word  (in_word),
        .keep  (map_keep),
        .entry (map_entry)
    );

    stat_pack_fifo #(
        .W     (ENTRY_W),
        .DEPTH (DEPTH)
    ) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (in_valid && map_keep),
        .wr_data (map_entry),
        .rd_en   (rd_en),
        .rd_data (rd_entry),
        .count   (fifo_count),
        .empty   (fifo_empty)
    );

    stat_pack_trig #(
        .CW          (CW),
        .PER_W       (PER_W),
        .TICK_CYCLES (TICK_CYCLES)
    ) u_trig (
        .clk         (clk),
        .rst_n       (rst_n),
        .count       (fifo_count),
        .periodic    (cfg_periodic),
        .threshold   (cfg_threshold),
        .period      (cfg_period_ms),
        .drain_done  (drain_done),
        .frame_start (frame_start)
    );

endmodule

// File: rtl/stat_pack_chk.sv
module stat_pack_chk #(
    parameter int ENTRY_W = 72,
    parameter int DS_W    = 64,
    parameter int DEPTH   = 64,
    parameter int CW      = 7
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               rd_en,
    input logic               drain_done,
    input logic [ENTRY_W-1:0] rd_entry,
    input logic [CW-1:0]      fifo_count,
    input logic               fifo_empty,
    input logic               frame_start
);

    logic       armed;
    logic [7:0] head_fs;

    assign head_fs = rd_entry[ENTRY_W-1 -: 8];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else if (frame_start) begin
            armed <= 1'b1;
        end else if (drain_done) begin
            armed <= 1'b0;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CW'(DEPTH)); // R5
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_count == CW'(DEPTH) && !rd_en) |=> (fifo_count == CW'(DEPTH))); // R5
    AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_count == '0 && !in_valid) |=> (fifo_count == '0)); // R5
    AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start); // R6
    AST_HOLD_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> !armed); // R8
    AST_FS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_empty |-> (head_fs == 8'h03 || head_fs == 8'h0C || head_fs == 8'h30)); // R1
    AST_NCD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_empty && head_fs == 8'h30) |-> (rd_entry[DS_W-1:0] == '0)); // R1

endmodule

bind stat_pack_chan stat_pack_chk #(
    .ENTRY_W (ENTRY_W),
    .DS_W    (DS_W),
    .DEPTH   (DEPTH),
    .CW      (CW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .rd_en       (rd_en),
    .drain_done  (drain_done),
    .rd_entry    (rd_entry),
    .fifo_count  (fifo_count),
    .fifo_empty  (fifo_empty),
    .frame_start (frame_start)
);

// File: tb/stat_pack_chan_test.sv
module stat_pack_chan_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic        va = 0, vc = 0, vu = 0;
    logic        ra = 0, rc = 0, ru = 0;
    logic [71:0] wd = '0;
    logic        per_a = 0;
    logic [6:0]  thr = 7'd64;
    logic        dd = 0;

    logic [39:0] ent_a;
    logic [71:0] ent_c, ent_u;
    logic [6:0]  cnt_a, cnt_c, cnt_u;
    logic        emp_a, emp_c, emp_u;
    logic        fs_a, fs_c, fs_u;

    stat_pack_chan #(.KIND(0), .TICK_CYCLES(4)) u_a429 (
        .clk(clk), .rst_n(rst_n), .in_valid(va), .in_word(wd[31:0]),
        .cfg_periodic(per_a), .cfg_threshold(thr), .cfg_period_ms(9'd5),
        .rd_en(ra), .drain_done(dd), .rd_entry(ent_a), .fifo_count(cnt_a),
        .fifo_empty(emp_a), .frame_start(fs_a));

    stat_pack_chan #(.KIND(1), .TICK_CYCLES(4)) u_can (
        .clk(clk), .rst_n(rst_n), .in_valid(vc), .in_word(wd[68:0]),
        .cfg_periodic(1'b0), .cfg_threshold(thr), .cfg_period_ms(9'd5),
        .rd_en(rc), .drain_done(dd), .rd_entry(ent_c), .fifo_count(cnt_c),
        .fifo_empty(emp_c), .frame_start(fs_c));

    stat_pack_chan #(.KIND(2), .UART_DS_W(64), .TICK_CYCLES(4)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(vu), .in_word(wd),
        .cfg_periodic(1'b0), .cfg_threshold(thr), .cfg_period_ms(9'd5),
        .rd_en(ru), .drain_done(dd), .rd_entry(ent_u), .fifo_count(cnt_u),
        .fifo_empty(emp_u), .frame_start(fs_u));

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    // {sel[1:0], word[71:0], keep, expected entry[71:0]}; sel 0=A429, 1=CAN, 2=UART
    localparam int NV = 15;
    localparam logic [146:0] VEC [NV] = '{
        {2'd0, 72'h0000000000_60000001, 1'b1, 72'h00000000_03_60000001},
        {2'd0, 72'h0000000000_C0000001, 1'b1, 72'h00000000_0C_C0000001},
        {2'd0, 72'h0000000000_A0000001, 1'b1, 72'h00000000_30_00000000},
        {2'd0, 72'h0000000000_00000001, 1'b0, 72'h0},
        {2'd0, 72'h0000000000_E0000001, 1'b0, 72'h0},
        {2'd1, 72'h08_A5A50F0F12345678, 1'b1, 72'h03_A5A50F0F12345678},
        {2'd1, 72'h18_A5A50F0F12345678, 1'b1, 72'h0C_A5A50F0F12345678},
        {2'd1, 72'h00_A5A50F0F12345678, 1'b1, 72'h30_0000000000000000},
        {2'd1, 72'h10_A5A50F0F12345678, 1'b0, 72'h0},
        {2'd1, 72'h04_A5A50F0F12345678, 1'b0, 72'h0},
        {2'd2, 72'h03_1122334455667788, 1'b1, 72'h03_1122334455667788},
        {2'd2, 72'h0C_1122334455667788, 1'b1, 72'h0C_1122334455667788},
        {2'd2, 72'h30_1122334455667788, 1'b1, 72'h30_0000000000000000},
        {2'd2, 72'h00_1122334455667788, 1'b0, 72'h0},
        {2'd2, 72'h05_1122334455667788, 1'b0, 72'h0}
    };

    task automatic check(input string req, input logic [71:0] act, input logic [71:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push(input int sel, input logic [71:0] w);
        @(negedge clk);
        wd = w;
        va = (sel == 0);
        vc = (sel == 1);
        vu = (sel == 2);
        @(negedge clk);
        va = 0; vc = 0; vu = 0;
    endtask

    task automatic pop(input int sel);
        @(negedge clk);
        ra = (sel == 0);
        rc = (sel == 1);
        ru = (sel == 2);
        @(negedge clk);
        ra = 0; rc = 0; ru = 0;
    endtask

    function automatic logic [71:0] cnt_of(input int sel);
        case (sel)
            0: return 72'(cnt_a);
            1: return 72'(cnt_c);
            default: return 72'(cnt_u);
        endcase
    endfunction

    function automatic logic [71:0] ent_of(input int sel);
        case (sel)
            0: return 72'(ent_a);
            1: return ent_c;
            default: return ent_u;
        endcase
    endfunction

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int pulses;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R9: reset state
        check("R9 count", cnt_of(0) | cnt_of(1) | cnt_of(2), 72'h0);
        check("R9 empty", 72'({emp_a, emp_c, emp_u}), 72'h7);
        check("R9 frame_start", 72'({fs_a, fs_c, fs_u}), 72'h0);

        // R1 R2 R3 R4: mapping table
        for (int i = 0; i < NV; i++) begin
            int sel;
            logic keep;
            sel  = int'(VEC[i][146:145]);
            keep = VEC[i][72];
            push(sel, VEC[i][144:73]);
            check($sformatf("R1 vector %0d kept count", i), cnt_of(sel), 72'(keep));
            if (keep) begin
                check($sformatf("R1 vector %0d entry", i), ent_of(sel), VEC[i][71:0]);
                pop(sel);
            end
        end

        // R5: fill past capacity, order, drop while full
        for (int i = 0; i < 65; i++) push(2, {8'h03, 64'(i)});
        check("R5 full count", cnt_of(2), 72'd64);
        for (int i = 0; i < 64; i++) begin
            if (i < 3 || i == 63) check($sformatf("R5 order %0d", i), ent_u, {8'h03, 64'(i)});
            pop(2);
        end
        check("R5 drained", cnt_of(2), 72'd0);
        pop(2);
        check("R5 read while empty count", cnt_of(2), 72'd0);
        check("R5 read while empty flag", 72'(emp_u), 72'd1);

        @(negedge clk); dd = 1;
        @(negedge clk); dd = 0;
        thr = 7'd3;

        // R6: event pulse timing
        push(2, {8'h03, 64'h1});
        push(2, {8'h03, 64'h2});
        check("R6 below threshold", 72'(fs_u), 72'd0);
        push(2, {8'h03, 64'h3});
        check("R6 write cycle", 72'(fs_u), 72'd0);
        @(negedge clk);
        check("R6 pulse cycle", 72'(fs_u), 72'd1);
        @(negedge clk);
        check("R6 pulse width", 72'(fs_u), 72'd0);

        // R8: held until drain_done, then refire
        push(2, {8'h03, 64'h4});
        pulses = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (fs_u) pulses++;
        end
        check("R8 no pulse before drain_done", 72'(pulses), 72'd0);
        dd = 1;
        @(negedge clk); dd = 0;
        check("R8 after drain_done", 72'(fs_u), 72'd0);
        @(negedge clk);
        check("R8 refire", 72'(fs_u), 72'd1);

        // R7: periodic mode on the ARINC 429 channel
        per_a = 1;
        pulses = 0;
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            if (fs_a) pulses++;
        end
        check("R7 empty period no pulse", 72'(pulses), 72'd0);
        push(0, 72'h60000001);
        pulses = 0;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (fs_a) pulses++;
        end
        check("R7 period pulse", 72'(pulses), 72'd1);

        finish_run();
    end

endmodule